// File: doc/BRIEF.md
# Secure State Transition Controller

This block keeps track of whether the processor runs in the secure or the non-secure state. For every control transfer it decides whether the transfer may cross the security boundary. Each branch event carries four things: a target address, a transfer kind, a flag saying whether the instruction fetched at the target is the gateway opcode, and the attribution of the target from the memory checker (secure, or callable from the non-secure side). The block answers one cycle later with the new security state, a redirected program counter, or a security fault.

Non-secure code can enter the secure side in only two ways. The first is to land on a gateway opcode inside a non-secure-callable region. The second is to branch to a reserved return value. That value pops an address that secure code saved in an 8-entry return stack held inside the block, which non-secure code cannot reach.

Branch events arrive on a valid/ready interface. The block never applies back-pressure: ready is always high, and every cycle with valid high is one accepted event. The outputs are plain pins that pulse for one cycle.

Top module: `sxc_ctrl`

## Requirements
- R1: After reset the state is secure (`sec_state`=1), the return stack is empty, and `pc_valid` and `fault` are low.
- R2: In the non-secure state, an ordinary branch (kind 0) to a target with `attr_nsc`=1 and `br_gateway`=1 moves the block to the secure state and redirects to the target.
- R3: In the non-secure state, an ordinary branch to a target with `attr_secure` or `attr_nsc` set is refused if it is not a gateway inside a callable region. A refused branch raises `fault`, gives no redirect, and leaves the state unchanged.
- R4: In the non-secure state, an ordinary branch to a target with neither attribute set stays non-secure and redirects to the target.
- R5: In the secure state, a non-secure call (kind 1) pushes `br_ret_addr` onto the return stack, switches to non-secure and redirects to the target.
- R6: In the non-secure state, an ordinary branch to 0xFEFFFFFF with a non-empty stack switches to secure. It redirects to the most recently pushed address and pops it, in last-in first-out order.
- R7: A branch to 0xFEFFFFFF in the non-secure state with an empty stack raises `fault`.
- R8: A non-secure call while 8 addresses are held raises `fault`, stays secure and stores nothing.
- R9: In the secure state, a return to non-secure (kind 2) switches to non-secure, redirects to the target and leaves the stack untouched.
- R10: Kinds 1 and 2 in the non-secure state fault, and kind 3 faults in both states.
- R11: Results appear in the cycle after the accepted event. `pc_valid` and `fault` are never high together, are low after a cycle without an event, and `br_ready` is always high.
- R12: In the secure state, an ordinary branch redirects to the target and stays secure, except that a branch to 0xFEFFFFFF faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch event present |
| br_ready | output | 1 | Always high; events are never stalled |
| br_kind | input | 2 | 0 ordinary, 1 non-secure call, 2 return to non-secure, 3 reserved |
| br_target | input | 32 | Branch target address |
| br_gateway | input | 1 | Instruction at the target is the gateway opcode |
| br_ret_addr | input | 32 | Return address saved by a non-secure call |
| attr_secure | input | 1 | Target attributed secure |
| attr_nsc | input | 1 | Target lies in a non-secure-callable region |
| sec_state | output | 1 | Current security state, 1 = secure |
| pc_valid | output | 1 | One-cycle pulse: redirect accepted |
| pc_out | output | 32 | Redirected program counter, meaningful with `pc_valid` |
| fault | output | 1 | One-cycle security fault pulse |

## Verification
The bound assertions check, on every cycle, the rules that can be seen from a single event:
- the outputs are quiet after an idle cycle and a redirect never coincides with a fault;
- a fault freezes the security state;
- only a gateway in a callable region or the reserved return value lets non-secure code turn secure;
- the stack level stays in range, grows by one on a legal call, and an empty stack makes the reserved value fault.

The bench's scenarios are needed for what depends on history. These are the last-in first-out order of popped addresses after eight nested calls, the refused ninth call leaving the stored addresses intact, and the exact redirected addresses.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  typedef enum logic [1:0] {
    BR_PLAIN  = 2'd0,
    BR_NSCALL = 2'd1,
    BR_NSRET  = 2'd2,
    BR_RSVD   = 2'd3
  } br_kind_e;
endpackage

// File: rtl/sxc_ret_stack.sv
module sxc_ret_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] level
);
  logic [AW-1:0] slot [DEPTH];
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign level = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (push && !full)    cnt_q <= cnt_q + 1'b1;
    else if (pop && !empty)    cnt_q <= cnt_q - 1'b1;
  end

  // one register per slot, written when the level points at it
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !full && cnt_q == CW'(i)) slot[i] <= push_data;
    end
  end

  always_comb begin
    top_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CW'(i + 1)) top_data = slot[i];
  end
endmodule

// File: rtl/sxc_decide.sv
module sxc_decide
  import sxc_pkg::*;
#(
  parameter int            AW        = 32,
  parameter logic [AW-1:0] RET_MAGIC = 32'hFEFF_FFFF
) (
  input  logic          valid,
  input  logic          cur_sec,
  input  br_kind_e      kind,
  input  logic [AW-1:0] target,
  input  logic          gateway,
  input  logic          attr_sec,
  input  logic          attr_nsc,
  input  logic          stk_full,
  input  logic          stk_empty,
  input  logic [AW-1:0] stk_top,
  output logic          nxt_sec,
  output logic          redir,
  output logic [AW-1:0] redir_pc,
  output logic          fault,
  output logic          push,
  output logic          pop
);
  logic is_magic, tgt_guarded;
  assign is_magic    = (target == RET_MAGIC);
  assign tgt_guarded = attr_sec | attr_nsc;

  always_comb begin
    nxt_sec  = cur_sec;
    redir    = 1'b0;
    redir_pc = target;
    fault    = 1'b0;
    push     = 1'b0;
    pop      = 1'b0;
    if (valid) begin
      if (cur_sec) begin
        unique case (kind)
          BR_PLAIN:  if (is_magic) fault = 1'b1; else redir = 1'b1;
          BR_NSCALL: if (stk_full) fault = 1'b1;
                     else begin push = 1'b1; nxt_sec = 1'b0; redir = 1'b1; end
          BR_NSRET:  begin nxt_sec = 1'b0; redir = 1'b1; end
          default:   fault = 1'b1;
        endcase
      end else begin
        unique case (kind)
          BR_PLAIN: begin
            if (is_magic) begin
              if (stk_empty) fault = 1'b1;
              else begin
                pop = 1'b1; nxt_sec = 1'b1; redir = 1'b1; redir_pc = stk_top;
              end
            end else if (tgt_guarded) begin
              if (attr_nsc && gateway) begin nxt_sec = 1'b1; redir = 1'b1; end
              else fault = 1'b1;
            end else redir = 1'b1;
          end
          default: fault = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/sxc_ctrl.sv
module sxc_ctrl
  import sxc_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            DEPTH     = 8,
  parameter logic [AW-1:0] RET_MAGIC = 32'hFEFF_FFFF,
  localparam int           CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  output logic          br_ready,
  input  logic [1:0]    br_kind,
  input  logic [AW-1:0] br_target,
  input  logic          br_gateway,
  input  logic [AW-1:0] br_ret_addr,
  input  logic          attr_secure,
  input  logic          attr_nsc,
  output logic          sec_state,
  output logic          pc_valid,
  output logic [AW-1:0] pc_out,
  output logic          fault
);
  logic          sec_q, pv_q, flt_q;
  logic [AW-1:0] pc_q;
  logic          d_sec, d_redir, d_fault, d_push, d_pop;
  logic [AW-1:0] d_pc, stk_top;
  logic          stk_full, stk_empty;
  logic [CW-1:0] stk_level;
  logic          accept;

  assign br_ready = 1'b1;
  assign accept   = br_valid & br_ready;

  sxc_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(d_push), .pop(d_pop),
    .push_data(br_ret_addr), .top_data(stk_top),
    .full(stk_full), .empty(stk_empty), .level(stk_level)
  );

  sxc_decide #(.AW(AW), .RET_MAGIC(RET_MAGIC)) u_dec (
    .valid(accept), .cur_sec(sec_q), .kind(br_kind_e'(br_kind)),
    .target(br_target), .gateway(br_gateway),
    .attr_sec(attr_secure), .attr_nsc(attr_nsc),
    .stk_full(stk_full), .stk_empty(stk_empty), .stk_top(stk_top),
    .nxt_sec(d_sec), .redir(d_redir), .redir_pc(d_pc),
    .fault(d_fault), .push(d_push), .pop(d_pop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q <= 1'b1;
      pv_q  <= 1'b0;
      flt_q <= 1'b0;
      pc_q  <= '0;
    end else begin
      sec_q <= d_sec;
      pv_q  <= d_redir;
      flt_q <= d_fault;
      if (d_redir) pc_q <= d_pc;
    end
  end

  assign sec_state = sec_q;
  assign pc_valid  = pv_q;
  assign pc_out    = pc_q;
  assign fault     = flt_q;
endmodule

// File: rtl/sxc_checker.sv
module sxc_checker #(
  parameter int            AW        = 32,
  parameter int            DEPTH     = 8,
  parameter logic [AW-1:0] RET_MAGIC = 32'hFEFF_FFFF,
  localparam int           CW        = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_valid,
  input logic [1:0]    br_kind,
  input logic [AW-1:0] br_target,
  input logic          br_gateway,
  input logic          attr_nsc,
  input logic          sec_state,
  input logic          pc_valid,
  input logic          fault,
  input logic [CW-1:0] level
);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> (!pc_valid && !fault));

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pc_valid && fault));

  p_fault_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && fault == 1'b0) |=> (fault |-> sec_state == $past(sec_state)));

  p_entry_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !sec_state && br_target != RET_MAGIC && !(attr_nsc && br_gateway))
      |=> !sec_state);

  p_empty_magic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !sec_state && br_kind == 2'd0 && br_target == RET_MAGIC && level == '0)
      |=> fault);

  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  p_call_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && sec_state && br_kind == 2'd1 && level != CW'(DEPTH))
      |=> (level == $past(level) + 1'b1 && !sec_state));
endmodule

bind sxc_ctrl sxc_checker #(.AW(AW), .DEPTH(DEPTH), .RET_MAGIC(RET_MAGIC)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
  .br_target(br_target), .br_gateway(br_gateway), .attr_nsc(attr_nsc),
  .sec_state(sec_state), .pc_valid(pc_valid), .fault(fault), .level(stk_level)
);

// File: tb/sxc_ctrl_bench.sv
module sxc_ctrl_bench;
  localparam logic [31:0] MAGIC = 32'hFEFF_FFFF;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0, br_gateway = 1'b0, attr_secure = 1'b0, attr_nsc = 1'b0;
  logic [1:0]  br_kind = 2'd0;
  logic [31:0] br_target = '0, br_ret_addr = '0;
  logic        br_ready, sec_state, pc_valid, fault;
  logic [31:0] pc_out;

  int checks = 0, errors = 0;
  bit m_sec = 1'b1;
  int unsigned stk[$];
  bit e_sec = 1'b1, e_pv = 1'b0, e_flt = 1'b0;
  logic [31:0] e_pc = '0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  sxc_ctrl u_sxc_ctrl (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_ready(br_ready),
    .br_kind(br_kind), .br_target(br_target), .br_gateway(br_gateway),
    .br_ret_addr(br_ret_addr), .attr_secure(attr_secure), .attr_nsc(attr_nsc),
    .sec_state(sec_state), .pc_valid(pc_valid), .pc_out(pc_out), .fault(fault)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("sec_state", 32'(sec_state), 32'(e_sec));
    chk("pc_valid", 32'(pc_valid), 32'(e_pv));
    chk("fault", 32'(fault), 32'(e_flt));
    chk("br_ready (R11)", 32'(br_ready), 32'd1);
    if (e_pv) chk("pc_out", pc_out, e_pc);
  endtask

  // reference model: compute what the block shows one cycle after this event
  task automatic model(bit v, int k, logic [31:0] t, bit gw, bit as, bit an, logic [31:0] ra);
    e_pv = 0; e_flt = 0; e_pc = t;
    if (v) begin
      if (m_sec) begin
        if (k == 0) begin if (t == MAGIC) e_flt = 1; else e_pv = 1; end
        else if (k == 1) begin
          if (stk.size() == 8) e_flt = 1;
          else begin stk.push_back(ra); m_sec = 0; e_pv = 1; end
        end
        else if (k == 2) begin m_sec = 0; e_pv = 1; end
        else e_flt = 1;
      end else begin
        if (k != 0) e_flt = 1;
        else if (t == MAGIC) begin
          if (stk.size() == 0) e_flt = 1;
          else begin e_pc = stk.pop_back(); m_sec = 1; e_pv = 1; end
        end else if (as || an) begin
          if (an && gw) begin m_sec = 1; e_pv = 1; end else e_flt = 1;
        end else e_pv = 1;
      end
    end
    e_sec = m_sec;
  endtask

  task automatic ev(string tag, bit v, int k, logic [31:0] t, bit gw, bit as, bit an,
                    logic [31:0] ra = 32'h0);
    @(negedge clk);
    compare();
    cur_tag = tag;
    model(v, k, t, gw, as, an, ra);
    br_valid = v; br_kind = 2'(k); br_target = t; br_gateway = gw;
    attr_secure = as; attr_nsc = an; br_ret_addr = ra;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cur_tag = "R1";
    ev("R12", 1, 0, 32'h0000_1000, 0, 1, 0);
    ev("R12", 1, 0, MAGIC, 0, 0, 0);
    ev("R5", 1, 1, 32'h0000_2000, 0, 0, 0, 32'h0000_1004);
    ev("R4", 1, 0, 32'h0000_2100, 0, 0, 0);
    ev("R3", 1, 0, 32'h0000_1200, 0, 1, 0);
    ev("R3", 1, 0, 32'h0000_1240, 1, 1, 0);
    ev("R3", 1, 0, 32'h0000_3000, 0, 0, 1);
    ev("R11", 0, 0, 32'h0000_3000, 1, 0, 1);
    ev("R11", 0, 0, 32'h0, 0, 0, 0);
    ev("R10", 1, 1, 32'h0000_2200, 0, 0, 0, 32'h5);
    ev("R10", 1, 2, 32'h0000_2200, 0, 0, 0);
    ev("R10", 1, 3, 32'h0000_2200, 0, 0, 0);
    ev("R6", 1, 0, MAGIC, 0, 0, 0);
    ev("R10", 1, 3, 32'h0000_1300, 0, 1, 0);
    ev("R9", 1, 2, 32'h0000_2400, 0, 0, 0);
    ev("R7", 1, 0, MAGIC, 0, 0, 0);
    ev("R2", 1, 0, 32'h0000_3008, 1, 1, 1);
    // fill the stack with 8 nested calls
    for (int i = 0; i < 8; i++) begin
      ev("R5", 1, 1, 32'h0000_4000 + 32'(i * 16), 0, 0, 0, 32'h0000_8000 + 32'(i * 4));
      ev("R2", 1, 0, 32'h0000_3000 + 32'(i * 4), 1, 0, 1);
    end
    ev("R8", 1, 1, 32'h0000_5000, 0, 0, 0, 32'hDEAD_0000);
    // unwind in reverse order; the refused address must never appear
    for (int i = 0; i < 8; i++) begin
      ev("R9", 1, 2, 32'h0000_6000, 0, 0, 0);
      ev("R6", 1, 0, MAGIC, 0, 0, 0);
    end
    ev("R9", 1, 2, 32'h0000_6100, 0, 0, 0);
    ev("R7", 1, 0, MAGIC, 0, 0, 0);
    ev("R11", 0, 0, 32'h0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule